// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects the external interrupt sources of a small 8-bit microcontroller and turns them into one request line for the CPU. The main source is an active-low request pin. Four general-purpose port pins can be joined to it as a group when a static parameter is set. A separate port pin has a pending flag and an enable of its own. Every pin passes through a two-flop synchroniser before any edge is detected. A pending flag latches the request. An enable bit gates the flag onto the CPU request, which stays asserted until software or the vector fetch removes the cause.

Software reaches the block through one 8-bit control/status register. It writes the two enable bits and two write-one acknowledge bits. It reads back the enables and both pending flags. How the main flag clears depends on the secondary enable. A vector-fetch strobe clears the flag only while the secondary enable is 0. Otherwise only the acknowledge bit clears it. A STOP/WAIT entry strobe forces the main enable on so that the pin can wake the part. It does not touch the secondary enable. All pins are plain control and status signals. No path in the block carries streamed data, so it has no valid/ready handshake.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x01 and irq_req is 0. Both flags are 0, the main enable (bit 0) is 1 and the secondary enable (bit 1) is 0.
- R2: A falling edge on the combined main source sets the main flag (rd_data bit 4) on the third rising clock edge after the pin change. In edge mode, a low level held on the source does not set the flag again once it has been cleared.
- R3: Writes to rd_data bits 4 and 5 have no effect on the flags. The acknowledge bits (write bits 2 and 3) always read back as 0.
- R4: Writing 1 to bit 2 clears the main flag whatever the secondary enable holds.
- R5: A vector_fetch pulse clears the main flag when the secondary enable is 0, and leaves the flag set when that enable is 1.
- R6: irq_req is 1 exactly when (main flag AND main enable) OR (secondary flag AND secondary enable). It stays 1 until one term is removed.
- R7: A stop_wait pulse sets the main enable to 1, and this takes priority over a register write in the same cycle. It leaves the secondary enable unchanged.
- R8: With PORT_GROUP_EN=1, a falling edge on any of port_n[3:0] sets the main flag exactly as the pin does. With PORT_GROUP_EN=0 the port pins have no effect.
- R9: With LEVEL_TRIG=1, a low level still present on the main source sets the flag again right after an acknowledge.
- R10: A falling edge on sec_n sets the secondary flag (rd_data bit 5). Only writing 1 to bit 3 clears it; neither vector_fetch nor the bit 2 acknowledge does.
- R11: When a set and a clear reach a flag in the same cycle, the set wins and the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Active-low external request pin |
| port_n | input | NUM_PORT | Active-low port pins joined to the main source when enabled |
| sec_n | input | 1 | Active-low secondary interrupt pin |
| vector_fetch | input | 1 | One-cycle strobe: the CPU fetched the interrupt vector |
| stop_wait | input | 1 | One-cycle strobe: the CPU enters STOP or WAIT |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit0 main enable, bit1 secondary enable, bit2 main ack, bit3 secondary ack |
| rd_data | output | 8 | Read data: bit0/1 enables, bit4 main flag, bit5 secondary flag, other bits 0 |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The main source is swept over each port pin in turn and over the request pin. In a level-triggered build, also without the port group, the port pins must leave the flag clear, which separates grouping from triggering. The two clear paths are tried with the secondary enable low and then high, so that a fetch which clears in the wrong case shows up. The acknowledge is also placed in the same cycle as a synchronised edge, which tells set-priority apart from clear-priority. Holding the pin low through an acknowledge separates the two trigger modes. The flag/enable combinations are walked to check the request equation.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int REG_W      = 8;
  localparam int B_MAIN_EN  = 0;
  localparam int B_SEC_EN   = 1;
  localparam int B_MAIN_ACK = 2;
  localparam int B_SEC_ACK  = 3;
  localparam int B_MAIN_FLG = 4;
  localparam int B_SEC_FLG  = 5;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eirq_trigger.sv
module eirq_trigger #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_n,
  output logic trig
);
  logic prev_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= src_n;

  generate
    if (LEVEL) begin : g_level
      assign trig = ~src_n;
    end else begin : g_edge
      assign trig = prev_n & ~src_n;
    end
  endgenerate
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;

  // R11: a set wins over a clear in the same cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R4: a clear with no set empties the flag
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_PORT      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter bit PORT_GROUP_EN = 1'b1,
  parameter bit LEVEL_TRIG    = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_n,
  input  logic [NUM_PORT-1:0] port_n,
  input  logic                sec_n,
  input  logic                vector_fetch,
  input  logic                stop_wait,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic                irq_req
);
  localparam int PIN_W = NUM_PORT + 2;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic main_src_n, main_set, main_clr, main_flag;
  logic sec_set, sec_clr, sec_flag;
  logic main_en, sec_en;
  logic unused_wr_hi;

  assign pins_raw = {sec_n, port_n, irq_n};
  assign unused_wr_hi = ^wr_data[REG_W-1:B_SEC_ACK+1];

  eirq_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  generate
    if (PORT_GROUP_EN) begin : g_group
      assign main_src_n = pins_s[0] & (&pins_s[NUM_PORT:1]);
    end else begin : g_alone
      logic unused_port;
      assign unused_port = ^pins_s[NUM_PORT:1];
      assign main_src_n  = pins_s[0];
    end
  endgenerate

  eirq_trigger #(.LEVEL(LEVEL_TRIG)) u_main_trig (
    .clk(clk), .rst_n(rst_n), .src_n(main_src_n), .trig(main_set)
  );
  eirq_trigger #(.LEVEL(1'b0)) u_sec_trig (
    .clk(clk), .rst_n(rst_n), .src_n(pins_s[PIN_W-1]), .trig(sec_set)
  );

  assign main_clr = (wr_en && wr_data[B_MAIN_ACK]) || (vector_fetch && !sec_en);
  assign sec_clr  = wr_en && wr_data[B_SEC_ACK];

  eirq_latch u_main_flag (
    .clk(clk), .rst_n(rst_n), .set(main_set), .clr(main_clr), .q(main_flag)
  );
  eirq_latch u_sec_flag (
    .clk(clk), .rst_n(rst_n), .set(sec_set), .clr(sec_clr), .q(sec_flag)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      main_en <= 1'b1;
      sec_en  <= 1'b0;
    end else begin
      if (stop_wait)  main_en <= 1'b1;
      else if (wr_en) main_en <= wr_data[B_MAIN_EN];
      if (wr_en)      sec_en  <= wr_data[B_SEC_EN];
    end

  always_comb begin
    rd_data             = '0;
    rd_data[B_MAIN_EN]  = main_en;
    rd_data[B_SEC_EN]   = sec_en;
    rd_data[B_MAIN_FLG] = main_flag;
    rd_data[B_SEC_FLG]  = sec_flag;
  end

  assign irq_req = (main_flag && main_en) || (sec_flag && sec_en);

  // R5: fetch clears the main flag only while the secondary enable is low
  a_r5_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_fetch && !sec_en && !main_set) |=> !main_flag);
  a_r5_fetch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_fetch && sec_en && main_flag && !wr_en) |=> main_flag);
  // R7: STOP/WAIT forces the main enable, secondary untouched
  a_r7_stop_enables: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wait |=> main_en);
  a_r7_sec_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wait && !wr_en) |=> $stable(sec_en));
  // R6: a pending, enabled request stays visible to the CPU
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (main_flag && main_en && !wr_en && !vector_fetch) |=> irq_req);
  // R10: the secondary flag survives anything but its own ack
  a_r10_sec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_flag && !(wr_en && wr_data[B_SEC_ACK])) |=> sec_flag);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_n = 1'b1;
  logic [3:0] port_n = 4'hF;
  logic       sec_n = 1'b1;
  logic       vector_fetch = 1'b0;
  logic       stop_wait = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic       req_a, req_b;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_n(port_n), .sec_n(sec_n),
    .vector_fetch(vector_fetch), .stop_wait(stop_wait), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_a), .irq_req(req_a)
  );

  ext_irq_ctrl #(.PORT_GROUP_EN(1'b0), .LEVEL_TRIG(1'b1)) dut_lvl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .port_n(port_n), .sec_n(sec_n),
    .vector_fetch(vector_fetch), .stop_wait(stop_wait), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_b), .irq_req(req_b)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    wait_n(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic fetch();
    vector_fetch = 1'b1;
    wait_n(1);
    vector_fetch = 1'b0;
  endtask

  task automatic stopw();
    stop_wait = 1'b1;
    wait_n(1);
    stop_wait = 1'b0;
  endtask

  // pulse main pin low for a while and release, leaving the flag set
  task automatic main_pulse();
    irq_n = 1'b0; wait_n(3);
    irq_n = 1'b1; wait_n(3);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk("R1 rd", rd_a, 8'h01);
    chk("R1 req", req_a, 0);
    chk("R1 rd lvl", rd_b, 8'h01);

    // R3 flag bits are read-only, acks read 0
    wr(8'hF1);
    chk("R3 flags unwritable", rd_a, 8'h01);
    wr(8'h0F);
    chk("R3 ack reads 0", rd_a, 8'h03);
    wr(8'h01);

    // R2 / R8 sweep over all main sources
    for (int src = 0; src < 5; src++) begin
      if (src == 4) irq_n = 1'b0; else port_n[src] = 1'b0;
      wait_n(2);
      chk("R2 not before 3rd edge", rd_a[4], 0);
      wait_n(1);
      chk("R2/R8 flag set", rd_a[4], 1);
      chk("R6 req", req_a, 1);
      chk("R8 group off", rd_b[4], (src == 4) ? 1 : 0);
      irq_n = 1'b1; port_n = 4'hF;
      wait_n(3);
      wr(8'h05);
      chk("R4 ack clears", rd_a[4], 0);
      chk("R4 ack clears lvl", rd_b[4], 0);
    end

    // R2 held low in edge mode: no retrigger after ack
    irq_n = 1'b0; wait_n(3);
    wr(8'h05);
    wait_n(2);
    chk("R2 no retrigger", rd_a[4], 0);
    chk("R9 level retrigger", rd_b[4], 1);
    irq_n = 1'b1; wait_n(3);
    wr(8'h05);
    chk("R9 cleared after release", rd_b[4], 0);

    // R5 fetch clear depends on secondary enable
    main_pulse();
    fetch();
    chk("R5 fetch clears", rd_a[4], 0);
    wr(8'h03);
    main_pulse();
    fetch();
    chk("R5 fetch blocked", rd_a[4], 1);
    wait_n(2);
    chk("R6 req held", req_a, 1);
    wr(8'h07);
    chk("R4 ack with sec_en", rd_a[4], 0);
    chk("R6 req drops", req_a, 0);

    // R6 flag x enable sweep
    wr(8'h01);
    main_pulse();
    for (int en = 0; en < 2; en++) begin
      wr(8'(en));
      chk("R6 req = flag&en", req_a, en);
      chk("R6 flag kept", rd_a[4], 1);
    end
    wr(8'h05);

    // R7 stop/wait
    wr(8'h02);
    stopw();
    chk("R7 stop sets en, keeps sec", rd_a[1:0], 2'b11);
    wr(8'h00);
    stopw();
    chk("R7 sec stays 0", rd_a[1:0], 2'b01);
    stop_wait = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    wait_n(1);
    stop_wait = 1'b0; wr_en = 1'b0;
    chk("R7 stop beats write", rd_a[0], 1);

    // R10 secondary flag
    sec_n = 1'b0; wait_n(3);
    chk("R10 sec set", rd_a[5], 1);
    chk("R6 sec masked", req_a, 0);
    wr(8'h03);
    chk("R6 sec req", req_a, 1);
    fetch();
    chk("R10 fetch no clear", rd_a[5], 1);
    wr(8'h07);
    chk("R10 main ack no clear", rd_a[5], 1);
    wr(8'h0B);
    chk("R10 own ack clears", rd_a[5], 0);
    sec_n = 1'b1; wait_n(3);
    chk("R10 release no set", rd_a[5], 0);
    wr(8'h01);

    // R11 set and ack in the same cycle
    irq_n = 1'b0; wait_n(2);
    wr_en = 1'b1; wr_data = 8'h05;
    wait_n(1);
    wr_en = 1'b0; wr_data = 8'h00;
    chk("R11 set wins", rd_a[4], 1);
    irq_n = 1'b1; wait_n(3);
    wr(8'h05);
    chk("R11 later ack", rd_a[4], 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule